// File: doc/BRIEF.md
# Operand Fetch Stage with Mode Decode

This block is the third stage of a five-stage pipeline whose instructions can read or write both registers and memory. Each cycle it takes one record from the address stage: an 8-bit opcode, a 4-bit register number and a 16-bit effective address. It splits the opcode into an ALU operation and a 4-bit addressing mode, and from the mode it decides where its two operands come from. It then registers everything the operate stage needs. The register file and the data memory sit outside the block. The stage drives a read address and a read request to each of them. Read data is returned in the same cycle, so the registered operands belong to the record that presented the address.

Operand A is the register value R[r] when the register-read bit is set. Otherwise it is the 4-bit register field itself, zero-extended; this gives cheap short-immediate modes. Operand B is the memory word at the effective address when the memory-read bit is set. Otherwise it is the effective address, zero-extended. The two write bits are not acted on in this stage. They ride along with the record so that the store stage can write the register, the memory word, or both.

An upstream interlock controls the stage through two inputs. Hold freezes the output record. Bubble loads an empty record, with no valid bit and no write intent, in place of the incoming one.

Top module: `of_stage`

## Requirements
- R1: While reset is asserted and right after it is released, out_valid, out_wr and out_wm are 0.
- R2: The opcode is split so that bits [7:4] are the ALU operation and bits [3:0] are the mode: bit 3 is register-read, bit 2 is memory-read, bit 1 is register-write and bit 0 is memory-write. A loaded record carries the ALU operation, r and ea unchanged to out_aluop, out_r and out_ea.
- R3: With register-read set on a valid input, rf_re is 1 and rf_raddr equals r in the same cycle. After the next edge, out_opa holds the rf_rdata value returned for that address.
- R4: With register-read clear, rf_re is 0 and out_opa after the next edge is r zero-extended to 32 bits.
- R5: With memory-read set on a valid input, mem_re is 1 and mem_raddr equals ea in the same cycle. After the next edge, out_opb holds the mem_rdata value returned for that address.
- R6: With memory-read clear, mem_re is 0 and out_opb after the next edge is ea zero-extended to 32 bits.
- R7: For a valid, non-bubble record, out_wr and out_wm equal the register-write and memory-write mode bits.
- R8: While hold is 1, every output of the stage register keeps its value, whatever the other inputs do, bubble included.
- R9: When bubble is 1 and hold is 0, the next record has out_valid, out_wr and out_wm equal to 0.
- R10: An input with in_valid at 0 loads a record with out_valid, out_wr and out_wm at 0, and it raises neither rf_re nor mem_re.
- R11: Mode 0001 yields operand A = zero-extended r with only the memory write set. Mode 0101 yields the same operand A, operand B = M[ea], and only the memory write set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming record is a real instruction |
| in_op | input | 8 | Opcode: ALU operation and mode |
| in_r | input | 4 | Register number field |
| in_ea | input | 16 | Effective address |
| hold | input | 1 | Freeze the output record |
| bubble | input | 1 | Load an empty record instead of the input |
| rf_re | output | 1 | Register value needed |
| rf_raddr | output | 4 | Register file read address |
| rf_rdata | input | 32 | Register file read data |
| mem_re | output | 1 | Memory word needed |
| mem_raddr | output | 16 | Memory read address |
| mem_rdata | input | 32 | Memory read data |
| out_valid | output | 1 | Output record is a real instruction |
| out_aluop | output | 4 | Forwarded ALU operation |
| out_r | output | 4 | Forwarded register number |
| out_ea | output | 16 | Forwarded effective address |
| out_wr | output | 1 | Store stage must write R[r] |
| out_wm | output | 1 | Store stage must write M[ea] |
| out_opa | output | 32 | Operand A |
| out_opb | output | 32 | Operand B |

## Verification
The hardest case to reach from the ports is a hold that overlaps both a bubble request and a changed input record. A fault in the priority between the two, or a leak through the enable, only shows if the frozen record differs from whatever would have replaced it. The stimulus loads a known record with both write bits set. It then asserts hold for several cycles while driving a different opcode, new addresses and bubble. It compares the outputs against the first record during the hold. After hold is released with bubble still asserted, it checks that the write intent is gone.

// File: rtl/of_pkg.sv
package of_pkg;
  localparam int unsigned MODE_W = 4;
  localparam int unsigned MB_RR = 3;
  localparam int unsigned MB_RM = 2;
  localparam int unsigned MB_WR = 1;
  localparam int unsigned MB_WM = 0;

  typedef struct packed {
    logic rd_reg;
    logic rd_mem;
    logic wr_reg;
    logic wr_mem;
  } mode_t;
endpackage

// File: rtl/of_mode_decode.sv
module of_mode_decode
  import of_pkg::*;
(
  input  logic [MODE_W-1:0] mode_bits,
  input  logic              valid,
  output mode_t             mode,
  output logic              need_reg,
  output logic              need_mem
);
  always_comb begin
    mode.rd_reg = mode_bits[MB_RR];
    mode.rd_mem = mode_bits[MB_RM];
    mode.wr_reg = mode_bits[MB_WR];
    mode.wr_mem = mode_bits[MB_WM];
    need_reg    = valid & mode.rd_reg;
    need_mem    = valid & mode.rd_mem;
  end
endmodule

// File: rtl/of_operand_sel.sv
module of_operand_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 4,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              sel_reg,
  input  logic              sel_mem,
  input  logic [REG_W-1:0]  r_field,
  input  logic [ADDR_W-1:0] ea,
  input  logic [DATA_W-1:0] rf_data,
  input  logic [DATA_W-1:0] mem_data,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb
);
  localparam int unsigned PAD_R = DATA_W - REG_W;
  localparam int unsigned PAD_A = DATA_W - ADDR_W;

  logic [DATA_W-1:0] r_ext;
  logic [DATA_W-1:0] ea_ext;

  always_comb begin
    r_ext  = {{PAD_R{1'b0}}, r_field};
    ea_ext = {{PAD_A{1'b0}}, ea};
    opa    = sel_reg ? rf_data  : r_ext;
    opb    = sel_mem ? mem_data : ea_ext;
  end
endmodule

// File: rtl/of_stage_reg.sv
module of_stage_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 4,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OPS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              d_valid,
  input  logic [OPS_W-1:0]  d_aluop,
  input  logic [REG_W-1:0]  d_r,
  input  logic [ADDR_W-1:0] d_ea,
  input  logic              d_wr,
  input  logic              d_wm,
  input  logic [DATA_W-1:0] d_opa,
  input  logic [DATA_W-1:0] d_opb,
  output logic              q_valid,
  output logic [OPS_W-1:0]  q_aluop,
  output logic [REG_W-1:0]  q_r,
  output logic [ADDR_W-1:0] q_ea,
  output logic              q_wr,
  output logic              q_wm,
  output logic [DATA_W-1:0] q_opa,
  output logic [DATA_W-1:0] q_opb
);
  logic              n_valid, n_wr, n_wm;
  logic [OPS_W-1:0]  n_aluop;
  logic [REG_W-1:0]  n_r;
  logic [ADDR_W-1:0] n_ea;
  logic [DATA_W-1:0] n_opa, n_opb;

  always_comb begin
    n_valid = q_valid;
    n_aluop = q_aluop;
    n_r     = q_r;
    n_ea    = q_ea;
    n_wr    = q_wr;
    n_wm    = q_wm;
    n_opa   = q_opa;
    n_opb   = q_opb;
    if (en) begin
      n_valid = d_valid;
      n_aluop = d_aluop;
      n_r     = d_r;
      n_ea    = d_ea;
      n_wr    = d_wr;
      n_wm    = d_wm;
      n_opa   = d_opa;
      n_opb   = d_opb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_aluop <= '0;
      q_r     <= '0;
      q_ea    <= '0;
      q_wr    <= 1'b0;
      q_wm    <= 1'b0;
      q_opa   <= '0;
      q_opb   <= '0;
    end else begin
      q_valid <= n_valid;
      q_aluop <= n_aluop;
      q_r     <= n_r;
      q_ea    <= n_ea;
      q_wr    <= n_wr;
      q_wm    <= n_wm;
      q_opa   <= n_opa;
      q_opb   <= n_opb;
    end
  end

  // R8: a disabled register keeps the whole record
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(q_valid) && $stable(q_opa) && $stable(q_opb) &&
             $stable(q_ea) && $stable(q_r) && $stable(q_wr) && $stable(q_wm)));

  // R7, R10: write intent never travels without a valid record
  p_write_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_wr || q_wm) |-> q_valid);
endmodule

// File: rtl/of_stage.sv
module of_stage
  import of_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 4,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [REG_W-1:0]  in_r,
  input  logic [ADDR_W-1:0] in_ea,
  input  logic              hold,
  input  logic              bubble,
  output logic              rf_re,
  output logic [REG_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              out_valid,
  output logic [OP_W-MODE_W-1:0] out_aluop,
  output logic [REG_W-1:0]  out_r,
  output logic [ADDR_W-1:0] out_ea,
  output logic              out_wr,
  output logic              out_wm,
  output logic [DATA_W-1:0] out_opa,
  output logic [DATA_W-1:0] out_opb
);
  localparam int unsigned OPS_W = OP_W - MODE_W;

  mode_t             mode;
  logic              ld_valid;
  logic              ld_wr, ld_wm;
  logic [DATA_W-1:0] sel_a, sel_b;

  of_mode_decode u_dec (
    .mode_bits (in_op[MODE_W-1:0]),
    .valid     (in_valid),
    .mode      (mode),
    .need_reg  (rf_re),
    .need_mem  (mem_re)
  );

  assign rf_raddr  = in_r;
  assign mem_raddr = in_ea;

  of_operand_sel #(.DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_sel (
    .sel_reg  (mode.rd_reg),
    .sel_mem  (mode.rd_mem),
    .r_field  (in_r),
    .ea       (in_ea),
    .rf_data  (rf_rdata),
    .mem_data (mem_rdata),
    .opa      (sel_a),
    .opb      (sel_b)
  );

  always_comb begin
    ld_valid = in_valid & ~bubble;
    ld_wr    = ld_valid & mode.wr_reg;
    ld_wm    = ld_valid & mode.wr_mem;
  end

  of_stage_reg #(.DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .OPS_W(OPS_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (~hold),
    .d_valid (ld_valid),
    .d_aluop (in_op[OP_W-1:MODE_W]),
    .d_r     (in_r),
    .d_ea    (in_ea),
    .d_wr    (ld_wr),
    .d_wm    (ld_wm),
    .d_opa   (sel_a),
    .d_opb   (sel_b),
    .q_valid (out_valid),
    .q_aluop (out_aluop),
    .q_r     (out_r),
    .q_ea    (out_ea),
    .q_wr    (out_wr),
    .q_wm    (out_wm),
    .q_opa   (out_opa),
    .q_opb   (out_opb)
  );

  // R3: a register-read record carries the value the file returned
  p_opa_from_rf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && in_valid && in_op[MB_RR]) |=> (out_opa == $past(rf_rdata)));

  // R4: no register read means operand A is the short immediate
  p_opa_short_imm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !in_op[MB_RR]) |=> (out_opa == DATA_W'($past(in_r))));

  // R6: no memory read means operand B is the address
  p_opb_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !in_op[MB_RM]) |=> (out_opb == DATA_W'($past(in_ea))));

  // R9: a bubble leaves no valid record and no write intent
  p_bubble_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && bubble) |=> (!out_valid && !out_wr && !out_wm));

  // R10: no read request for an invalid input
  p_no_req_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!rf_re && !mem_re));
endmodule

// File: tb/tb_of_stage.sv
`timescale 1ns/1ps
module tb_of_stage;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_op;
  logic [3:0]  in_r;
  logic [15:0] in_ea;
  logic        hold, bubble;
  logic        rf_re, mem_re;
  logic [3:0]  rf_raddr;
  logic [15:0] mem_raddr;
  logic [31:0] rf_rdata, mem_rdata;
  logic        out_valid, out_wr, out_wm;
  logic [3:0]  out_aluop, out_r;
  logic [15:0] out_ea;
  logic [31:0] out_opa, out_opb;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  of_stage dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_r(in_r),
    .in_ea(in_ea), .hold(hold), .bubble(bubble), .rf_re(rf_re), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_aluop(out_aluop), .out_r(out_r), .out_ea(out_ea),
    .out_wr(out_wr), .out_wm(out_wm), .out_opa(out_opa), .out_opb(out_opb)
  );

  function automatic logic [31:0] rf_val(input logic [3:0] a);
    return 32'hC0DE_0000 + 32'(a) * 32'h0000_0111;
  endfunction
  function automatic logic [31:0] mem_val(input logic [15:0] a);
    return {a ^ 16'h5A5A, ~a};
  endfunction

  // external storage models, combinational read
  assign rf_rdata  = rf_val(rf_raddr);
  assign mem_rdata = mem_val(mem_raddr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] op, input logic [3:0] r,
                       input logic [15:0] ea, input logic h, input logic b);
    in_valid = v; in_op = op; in_r = r; in_ea = ea; hold = h; bubble = b;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // full check of one valid record through all mode paths
  task automatic run_record(input string req, input logic [7:0] op,
                            input logic [3:0] r, input logic [15:0] ea);
    logic [31:0] ea_v, ra, rb;
    drive(1'b1, op, r, ea, 1'b0, 1'b0);
    #0.5;
    chk({req, " R3 rf_re"},  32'(rf_re),  32'(op[3]));
    chk({req, " R5 mem_re"}, 32'(mem_re), 32'(op[2]));
    if (op[3]) chk({req, " R3 rf_raddr"}, 32'(rf_raddr), 32'(r));
    if (op[2]) chk({req, " R5 mem_raddr"}, 32'(mem_raddr), 32'(ea));
    step();
    ea_v = {16'h0, ea};
    ra = op[3] ? rf_val(r) : {28'h0, r};
    rb = op[2] ? mem_val(ea) : ea_v;
    chk({req, (op[3] ? " R3" : " R4"), " opa"}, out_opa, ra);
    chk({req, (op[2] ? " R5" : " R6"), " opb"}, out_opb, rb);
    chk({req, " R7 wr"}, 32'(out_wr), 32'(op[1]));
    chk({req, " R7 wm"}, 32'(out_wm), 32'(op[0]));
    chk({req, " R2 aluop"}, 32'(out_aluop), 32'(op[7:4]));
    chk({req, " R2 r"}, 32'(out_r), 32'(r));
    chk({req, " R2 ea"}, 32'(out_ea), ea_v);
    chk({req, " R2 valid"}, 32'(out_valid), 32'd1);
  endtask

  task automatic t_reset();
    drive(1'b1, 8'hFF, 4'h7, 16'hBEEF, 1'b0, 1'b0);
    rst_n = 1'b0;
    repeat (3) step();
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    chk("R1 wr in reset", 32'(out_wr), 32'd0);
    chk("R1 wm in reset", 32'(out_wm), 32'd0);
    drive(1'b0, 8'h00, 4'h0, 16'h0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step();
    chk("R1 valid after release", 32'(out_valid), 32'd0);
    chk("R1 writes after release", 32'({out_wr, out_wm}), 32'd0);
  endtask

  task automatic t_modes();
    run_record("reg+imm", 8'h3A, 4'h5, 16'h1234);
    run_record("mem to reg", 8'h56, 4'h9, 16'hF00D);
    run_record("reg+mem both", 8'hEF, 4'hF, 16'hFFFF);
    run_record("imm to reg", 8'h12, 4'h0, 16'h8001);
    for (int m = 0; m < 16; m++)
      run_record("sweep", {4'(m), 4'(m)}, 4'(15 - m), 16'(m * 16'h1111 + 3));
  endtask

  task automatic t_short_imm();
    run_record("R11 mode 0001", 8'h71, 4'hC, 16'h0042);
    run_record("R11 mode 0101", 8'h25, 4'h3, 16'hA0A0);
    chk("R11 0101 only wm", 32'({out_wr, out_wm}), 32'd1);
  endtask

  task automatic t_hold();
    run_record("hold base", 8'h9F, 4'h6, 16'h4321);
    drive(1'b1, 8'h40, 4'h1, 16'h0101, 1'b1, 1'b1);
    step();
    drive(1'b0, 8'hAA, 4'h2, 16'h7777, 1'b1, 1'b0);
    step();
    chk("R8 opa held", out_opa, rf_val(4'h6));
    chk("R8 opb held", out_opb, mem_val(16'h4321));
    chk("R8 ea held", 32'(out_ea), 32'h4321);
    chk("R8 valid/wr/wm held", 32'({out_valid, out_wr, out_wm}), 32'd7);
    drive(1'b1, 8'h8F, 4'h4, 16'h0202, 1'b0, 1'b1);
    step();
    chk("R9 bubble after hold", 32'({out_valid, out_wr, out_wm}), 32'd0);
  endtask

  task automatic t_bubble_invalid();
    drive(1'b1, 8'hF3, 4'h8, 16'h1111, 1'b0, 1'b1);
    step();
    chk("R9 bubble valid", 32'(out_valid), 32'd0);
    chk("R9 bubble writes", 32'({out_wr, out_wm}), 32'd0);
    drive(1'b0, 8'hCF, 4'hA, 16'h2222, 1'b0, 1'b0);
    #0.5;
    chk("R10 no reg request", 32'(rf_re), 32'd0);
    chk("R10 no mem request", 32'(mem_re), 32'd0);
    step();
    chk("R10 invalid record", 32'({out_valid, out_wr, out_wm}), 32'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_modes();
    t_short_imm();
    t_hold();
    t_bubble_invalid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule